// File: doc/BRIEF.md
# Secondary Interrupt Controller with Line Bypass

This block gathers 32 level-sensitive interrupt lines that sit below a primary vectored controller. Every clock it captures the level of each line into a raw level vector. A programmable enable mask selects which captured lines may contribute to one combined request. The combined request is the OR of all lines that are both high and enabled, and it is driven on upstream line 31.

A window of inputs, lines 21 to 30 by default, can also bypass the merge. When the bypass bit of such a line is set, the matching upstream line copies that input's level. When the bit is clear, the upstream line is held low. Upstream lines 0 to 20 are always low.

Software reaches the block through a single-cycle register port with select, write, byte address, and 32-bit write and read data. Registers are chosen by the byte address divided by four inside a 4 KB window. All outputs come from flops and change one clock after the cause.

Top module: `sec_irq_ctrl`

## Requirements
- R1: Each clock the raw level vector captures `irq_in`. A read of word 1 (byte offset 0x04) returns it.
- R2: Upstream line 31 is high exactly when the raw level AND the enable mask is nonzero.
- R3: A write to word 2 (0x08) ORs the data into the enable mask. A write to word 3 (0x0C) clears every mask bit that is set in the data. A read of word 2 returns the mask.
- R4: A nonzero write to word 4 (0x10) sets mask bit 0, and a nonzero write to word 5 (0x14) clears it. A zero write to either word leaves the mask unchanged. A read of word 4 returns raw level bit 0 in bit 0, with all other bits zero.
- R5: A write to word 8 (0x20) sets bypass-enable bits, but only bits 21 to 30 can be set. A write to word 9 (0x24) clears the bypass-enable bits set in the data. A read of word 8 returns the bypass-enable register.
- R6: For each line 21 to 30, the upstream line equals the raw level when its bypass bit is set, and is low otherwise. Upstream lines 0 to 20 are always low.
- R7: A read of word 0 (0x00) returns the raw level AND the enable mask.
- R8: A read from any other word returns zero. A write to any other word changes neither the mask nor the bypass enables.
- R9: The upstream lines change on the first clock edge after an input change or register write, and not before it.
- R10: Reset clears the mask, the bypass enables, the raw level and all upstream lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | 32 | Level-sensitive interrupt inputs |
| psel | input | 1 | Register access select |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address in the 4 KB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while psel is high and pwrite is low |
| irq_up_o | output | 32 | Upstream lines: bit 31 is the combined request, bits 21 to 30 are the bypass lines |

## Verification
The combined request is driven with a single enabled line, with several lines of which only some are enabled, and with active lines that are all masked. These cases separate a correct AND-then-OR from one that ignores the mask or reads only one bit. The bypass lines are tried with the enable set and the input high, with the enable set and the input low, and after a selective clear. This shows that the lines follow the input and not a stored copy, and that one line can be cleared without touching its neighbours. Writes of zero and of all ones to the soft-interrupt words, to the bypass-set word and to an unused word confirm that only the intended bits move. A directed test catches the upstream line before and after the edge that should move it.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  // register word indices (byte address >> 2)
  localparam int unsigned WRD_MSTAT    = 0;
  localparam int unsigned WRD_RAW      = 1;
  localparam int unsigned WRD_MASK_SET = 2;
  localparam int unsigned WRD_MASK_CLR = 3;
  localparam int unsigned WRD_SOFT_SET = 4;
  localparam int unsigned WRD_SOFT_CLR = 5;
  localparam int unsigned WRD_BYP_SET  = 8;
  localparam int unsigned WRD_BYP_CLR  = 9;

  function automatic logic [31:0] window_bits(input int unsigned lo, input int unsigned hi);
    logic [31:0] r;
    r = '0;
    for (int unsigned i = 0; i < 32; i++) begin
      if (i >= lo && i <= hi) r[i] = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/sirq_level_capture.sv
module sirq_level_capture #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  output logic [N-1:0] raw_nxt,
  output logic [N-1:0] raw_q
);
  logic cap_en;

  always_comb begin
    cap_en  = 1'b1;
    raw_nxt = irq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
    end else if (cap_en) begin
      raw_q <= raw_nxt;
    end
  end
endmodule

// File: rtl/sirq_regbank.sv
module sirq_regbank
  import sirq_pkg::*;
#(
  parameter int N      = 32,
  parameter int WORD_W = 10,
  parameter logic [N-1:0] BYP_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [WORD_W-1:0] word,
  input  logic [N-1:0]      wdata,
  input  logic [N-1:0]      raw_q,
  output logic [N-1:0]      rdata,
  output logic [N-1:0]      mask_q,
  output logic [N-1:0]      byp_q,
  output logic [N-1:0]      mask_nxt,
  output logic [N-1:0]      byp_nxt
);
  localparam logic [WORD_W-1:0] W_MSTAT    = WORD_W'(WRD_MSTAT);
  localparam logic [WORD_W-1:0] W_RAW      = WORD_W'(WRD_RAW);
  localparam logic [WORD_W-1:0] W_MASK_SET = WORD_W'(WRD_MASK_SET);
  localparam logic [WORD_W-1:0] W_MASK_CLR = WORD_W'(WRD_MASK_CLR);
  localparam logic [WORD_W-1:0] W_SOFT_SET = WORD_W'(WRD_SOFT_SET);
  localparam logic [WORD_W-1:0] W_SOFT_CLR = WORD_W'(WRD_SOFT_CLR);
  localparam logic [WORD_W-1:0] W_BYP_SET  = WORD_W'(WRD_BYP_SET);
  localparam logic [WORD_W-1:0] W_BYP_CLR  = WORD_W'(WRD_BYP_CLR);
  localparam logic [N-1:0]      SOFT_BIT   = N'(1);

  logic data_nz;
  logic mask_en;
  logic byp_en;

  assign data_nz = |wdata;

  // next-state for mask and bypass enables
  always_comb begin
    mask_nxt = mask_q;
    byp_nxt  = byp_q;
    mask_en  = 1'b0;
    byp_en   = 1'b0;
    if (wr_en) begin
      case (word)
        W_MASK_SET: begin
          mask_nxt = mask_q | wdata;
          mask_en  = 1'b1;
        end
        W_MASK_CLR: begin
          mask_nxt = mask_q & ~wdata;
          mask_en  = 1'b1;
        end
        W_SOFT_SET: begin
          if (data_nz) mask_nxt = mask_q | SOFT_BIT;
          mask_en = data_nz;
        end
        W_SOFT_CLR: begin
          if (data_nz) mask_nxt = mask_q & ~SOFT_BIT;
          mask_en = data_nz;
        end
        W_BYP_SET: begin
          byp_nxt = byp_q | (wdata & BYP_MASK);
          byp_en  = 1'b1;
        end
        W_BYP_CLR: begin
          byp_nxt = byp_q & ~wdata;
          byp_en  = 1'b1;
        end
        default: begin
          mask_nxt = mask_q;
          byp_nxt  = byp_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byp_q <= '0;
    end else if (byp_en) begin
      byp_q <= byp_nxt;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (word)
        W_MSTAT:    rdata = raw_q & mask_q;
        W_RAW:      rdata = raw_q;
        W_MASK_SET: rdata = mask_q;
        W_SOFT_SET: rdata = raw_q & SOFT_BIT;
        W_BYP_SET:  rdata = byp_q;
        default:    rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/sirq_route.sv
module sirq_route #(
  parameter int N        = 32,
  parameter int SUM_LINE = 31,
  parameter logic [N-1:0] BYP_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_nxt,
  input  logic [N-1:0] mask_nxt,
  input  logic [N-1:0] byp_nxt,
  output logic [N-1:0] up_q
);
  logic any_nxt;
  logic byp_unused;

  assign any_nxt    = |(raw_nxt & mask_nxt);
  assign byp_unused = ^(byp_nxt & ~BYP_MASK);

  for (genvar i = 0; i < N; i++) begin : g_line
    if (i == SUM_LINE) begin : g_sum
      logic d;
      assign d = any_nxt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) up_q[i] <= 1'b0;
        else        up_q[i] <= d;
      end
    end else if (BYP_MASK[i]) begin : g_byp
      logic d;
      assign d = byp_nxt[i] & raw_nxt[i];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) up_q[i] <= 1'b0;
        else        up_q[i] <= d;
      end
    end else begin : g_quiet
      assign up_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/sec_irq_ctrl.sv
module sec_irq_ctrl #(
  parameter int N        = 32,
  parameter int ADDR_W   = 12,
  parameter int BYP_LO   = 21,
  parameter int BYP_HI   = 30,
  parameter int SUM_LINE = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      irq_in,
  input  logic              psel,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [N-1:0]      pwdata,
  output logic [N-1:0]      prdata,
  output logic [N-1:0]      irq_up_o
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [N-1:0] BYP_MASK = N'(sirq_pkg::window_bits(BYP_LO, BYP_HI));

  logic              rst_meta_n;
  logic              rst_sync_n;
  logic              wr_en;
  logic              rd_en;
  logic [WORD_W-1:0] word_sel;
  logic              addr_unused;
  logic [N-1:0]      raw_nxt, raw_q;
  logic [N-1:0]      mask_q, mask_nxt;
  logic [N-1:0]      byp_q, byp_nxt;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign wr_en       = psel & pwrite;
  assign rd_en       = psel & ~pwrite;
  assign word_sel    = paddr[ADDR_W-1:2];
  assign addr_unused = ^paddr[1:0];

  sirq_level_capture #(.N(N)) u_cap (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .irq_in  (irq_in),
    .raw_nxt (raw_nxt),
    .raw_q   (raw_q)
  );

  sirq_regbank #(.N(N), .WORD_W(WORD_W), .BYP_MASK(BYP_MASK)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .word     (word_sel),
    .wdata    (pwdata),
    .raw_q    (raw_q),
    .rdata    (prdata),
    .mask_q   (mask_q),
    .byp_q    (byp_q),
    .mask_nxt (mask_nxt),
    .byp_nxt  (byp_nxt)
  );

  sirq_route #(.N(N), .SUM_LINE(SUM_LINE), .BYP_MASK(BYP_MASK)) u_route (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .raw_nxt  (raw_nxt),
    .mask_nxt (mask_nxt),
    .byp_nxt  (byp_nxt),
    .up_q     (irq_up_o)
  );
endmodule

// File: rtl/sirq_checker.sv
module sirq_checker #(
  parameter int N        = 32,
  parameter int WORD_W   = 10,
  parameter int SUM_LINE = 31,
  parameter logic [N-1:0] BYP_MASK = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [WORD_W-1:0] word,
  input logic [N-1:0]      wdata,
  input logic [N-1:0]      raw_q,
  input logic [N-1:0]      mask_q,
  input logic [N-1:0]      byp_q,
  input logic [N-1:0]      up
);
  localparam logic [N-1:0] SUM_BIT = N'(1) << SUM_LINE;

  logic listed;
  assign listed = (word == WORD_W'(2)) || (word == WORD_W'(3)) || (word == WORD_W'(4)) ||
                  (word == WORD_W'(5)) || (word == WORD_W'(8)) || (word == WORD_W'(9));

  // R3
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == WORD_W'(2)) |=> ((mask_q & $past(wdata)) == $past(wdata)));

  // R3
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == WORD_W'(3)) |=> ((mask_q & $past(wdata)) == '0));

  // R5
  byp_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byp_q & ~BYP_MASK) == '0);

  // R2
  summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up[SUM_LINE] == |(raw_q & mask_q));

  // R6
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up & BYP_MASK) == (raw_q & byp_q & BYP_MASK));

  // R6
  quiet_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up & ~(BYP_MASK | SUM_BIT)) == '0);

  // R8
  unlisted_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !listed) |=> ($stable(mask_q) && $stable(byp_q)));
endmodule

bind sec_irq_ctrl sirq_checker #(
  .N(N), .WORD_W(WORD_W), .SUM_LINE(SUM_LINE), .BYP_MASK(BYP_MASK)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .wr_en  (wr_en),
  .word   (word_sel),
  .wdata  (pwdata),
  .raw_q  (raw_q),
  .mask_q (mask_q),
  .byp_q  (byp_q),
  .up     (irq_up_o)
);

// File: tb/tb_sec_irq_ctrl.sv
module tb_sec_irq_ctrl;
  logic        clk;
  logic        rst_n;
  logic [31:0] irq_in;
  logic        psel;
  logic        pwrite;
  logic [11:0] paddr;
  logic [31:0] pwdata;
  logic [31:0] prdata;
  logic [31:0] irq_up_o;

  int checks;
  int fails;
  bit done;

  sec_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .psel(psel), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq_up_o(irq_up_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [7:0]  req;
    logic [31:0] irq;
    logic        wr;
    logic [9:0]  ww;
    logic [31:0] wd;
    logic [9:0]  rw;
    logic [31:0] erd;
    logic [31:0] eup;
  } vec_t;

  localparam int NV = 18;
  // each row: req, irq, wr, write word, write data, read word, expected read, expected upstream
  localparam vec_t VECS [NV] = '{
    '{8'd1,  32'h0000_0008, 1'b0, 10'd0, 32'h0,          10'd1, 32'h0000_0008, 32'h0},          // R1 raw capture
    '{8'd2,  32'h0000_0008, 1'b1, 10'd2, 32'h0000_0008,  10'd0, 32'h0000_0008, 32'h8000_0000},  // R2 R7
    '{8'd2,  32'h0000_0000, 1'b0, 10'd0, 32'h0,          10'd0, 32'h0,         32'h0},          // R2 input drops
    '{8'd3,  32'h0000_0018, 1'b1, 10'd2, 32'h0000_0010,  10'd2, 32'h0000_0018, 32'h8000_0000},  // R3 OR set
    '{8'd3,  32'h0000_0018, 1'b1, 10'd3, 32'h0000_0018,  10'd0, 32'h0,         32'h0},          // R3 clear
    '{8'd4,  32'h0000_0001, 1'b1, 10'd4, 32'h0,          10'd2, 32'h0,         32'h0},          // R4 zero set ignored
    '{8'd4,  32'h0000_0001, 1'b1, 10'd4, 32'h0000_0005,  10'd4, 32'h0000_0001, 32'h8000_0000},  // R4 soft set
    '{8'd4,  32'h0000_0001, 1'b1, 10'd5, 32'h0,          10'd2, 32'h0000_0001, 32'h8000_0000},  // R4 zero clear ignored
    '{8'd4,  32'h0000_0001, 1'b1, 10'd5, 32'h0000_FFFF,  10'd2, 32'h0,         32'h0},          // R4 soft clear
    '{8'd5,  32'h4020_0000, 1'b1, 10'd8, 32'hFFFF_FFFF,  10'd8, 32'h7FE0_0000, 32'h4020_0000},  // R5 R6 window only
    '{8'd6,  32'h0040_0000, 1'b0, 10'd0, 32'h0,          10'd1, 32'h0040_0000, 32'h0040_0000},  // R6 follows input
    '{8'd5,  32'h0040_0000, 1'b1, 10'd9, 32'h0040_0000,  10'd8, 32'h7FA0_0000, 32'h0},          // R5 selective clear
    '{8'd8,  32'h8040_0001, 1'b1, 10'd6, 32'hFFFF_FFFF,  10'd2, 32'h0,         32'h0},          // R8 unlisted write
    '{8'd8,  32'h8040_0001, 1'b0, 10'd0, 32'h0,          10'd7, 32'h0,         32'h0},          // R8 unlisted read
    '{8'd7,  32'h2000_0000, 1'b1, 10'd2, 32'h2000_0000,  10'd0, 32'h2000_0000, 32'hA000_0000},  // R7 R2 R6
    '{8'd7,  32'h0000_0000, 1'b0, 10'd0, 32'h0,          10'd0, 32'h0,         32'h0},          // R7 masked status low
    '{8'd6,  32'h2000_0000, 1'b1, 10'd9, 32'hFFFF_FFFF,  10'd8, 32'h0,         32'h8000_0000},  // R6 bypass off drives low
    '{8'd8,  32'h2000_0000, 1'b0, 10'd0, 32'h0,          10'd12, 32'h0,        32'h8000_0000}   // R8 read of word 12
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic rd_word(input logic [9:0] w, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = {w, 2'b00};
    #1 d = prdata;
    @(negedge clk);
    psel = 1'b0;
  endtask

  initial begin : watchdog
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; irq_in = '0; psel = 1'b0; pwrite = 1'b0; paddr = '0; pwdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 up in reset", irq_up_o, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_word(10'd2, d); check("R10 mask after reset", d, 32'h0);
    rd_word(10'd8, d); check("R10 bypass after reset", d, 32'h0);
    check("R10 up after reset", irq_up_o, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      irq_in = VECS[i].irq;
      psel   = VECS[i].wr;
      pwrite = 1'b1;
      paddr  = {VECS[i].ww, 2'b00};
      pwdata = VECS[i].wd;
      @(negedge clk);
      psel = 1'b1; pwrite = 1'b0; paddr = {VECS[i].rw, 2'b00};
      #1;
      check($sformatf("R%0d vec%0d read", VECS[i].req, i), prdata, VECS[i].erd);
      check($sformatf("R%0d vec%0d upstream", VECS[i].req, i), irq_up_o, VECS[i].eup);
      @(negedge clk);
      psel = 1'b0;
    end

    // R9: input drop seen only after the next edge
    @(negedge clk);
    irq_in = 32'h0;
    #1 check("R9 before edge", irq_up_o, 32'h8000_0000);
    @(negedge clk);
    check("R9 after edge", irq_up_o, 32'h0);

    // R9: write takes effect one edge later
    @(negedge clk);
    irq_in = 32'h0100_0000;
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = {10'd8, 2'b00}; pwdata = 32'h0100_0000;
    #1 check("R9 bypass before edge", irq_up_o, 32'h0);
    @(negedge clk);
    psel = 1'b0;
    check("R9 bypass after edge", irq_up_o, 32'h0100_0000);

    // R10: reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R10 async clear", irq_up_o, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_word(10'd0, d); check("R10 masked status after reset", d, 32'h0);
    rd_word(10'd8, d); check("R10 bypass cleared", d, 32'h0);
    check("R10 upstream after reset", irq_up_o, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule